// File: doc/BRIEF.md
# Fan-Out Multiplicity Wiring Checker

This unit sits next to an arithmetic-circuit evaluation engine and checks that the engine wires its nodes consistently. A node is created with an identifier, a value and a declared fan-out count. The count is a signed use budget that later operand reads spend one at a time. An operand read must name a node that exists and must carry the value that was stored for it. Any read that does not meet this raises a sticky error. When the evaluation ends, a scan walks every entry and reports whether every budget came out at exactly zero.

In one cycle the engine can present up to two creations, which is a read step that loads a pair of variables. It can instead present one creation and two operand reads, which is an evaluation step. A clear strobe empties the table before each evaluation, so nodes left over from one evaluation never match reads from the next. Padding variables that no instruction uses are created with a budget of zero. They are balanced without ever being read.

Top module: `fanout_wire_checker`

## Requirements
- R1: One cycle after `clr_i`, every entry is empty with a count of zero, and `err_o` and `done_o` are 0. `clr_i` takes priority over every other strobe in its cycle.
- R2: A creation on slot 0 or slot 1 stores the value and loads the count with the fan-out. If both slots name the same identifier in one cycle, slot 1 wins.
- R3: An operand read of an existing node with the stored value lowers that node's count by one and does not raise the error.
- R4: When both operands of one step name the same node, that node's count falls by two in that cycle.
- R5: An operand read of an identifier that has not been created since the last clear sets `err_o` on the next cycle.
- R6: An operand read whose value differs from the stored value sets `err_o`. The count is still lowered.
- R7: `err_o` stays set until the next `clr_i`.
- R8: After `end_i`, `done_o` rises exactly 2^ID_W cycles later. `bal_o` is then 1 when every count is zero and 0 otherwise.
- R9: A node created with fan-out zero and never read counts as balanced. A node read more times than its fan-out (a negative count) or fewer times counts as unbalanced.
- R10: A creation and an operand read of the same identifier in one cycle are handled as follows. The read is judged against the table as it was before that cycle, so it is an error if the node did not exist yet. The stored count becomes the fan-out minus the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Empty the table and clear the flags |
| ins0_vld_i | input | 1 | Creation on slot 0 |
| ins0_id_i | input | ID_W | Slot 0 identifier |
| ins0_val_i | input | VAL_W | Slot 0 node value |
| ins0_fan_i | input | CNT_W | Slot 0 declared fan-out |
| ins1_vld_i | input | 1 | Creation on slot 1 |
| ins1_id_i | input | ID_W | Slot 1 identifier |
| ins1_val_i | input | VAL_W | Slot 1 node value |
| ins1_fan_i | input | CNT_W | Slot 1 declared fan-out |
| opa_vld_i | input | 1 | Operand A read |
| opa_id_i | input | ID_W | Operand A identifier |
| opa_val_i | input | VAL_W | Operand A value as seen by the engine |
| opb_vld_i | input | 1 | Operand B read |
| opb_id_i | input | ID_W | Operand B identifier |
| opb_val_i | input | VAL_W | Operand B value as seen by the engine |
| end_i | input | 1 | Start the balance scan |
| err_o | output | 1 | Sticky wiring error |
| done_o | output | 1 | Scan complete |
| bal_o | output | 1 | All counts zero (valid with done_o) |

## Verification
Two things can hit one entry in the same cycle, and both cases are forced on purpose. In the first, a creation lands on the very identifier that an operand reads. In the second, both operands name one node. A behavioural model in the bench applies creations first and then reads, judging each read against the table as it stood before the edge. The model is compared with `err_o` on every cycle and with `bal_o` when the scan completes. Either case, if handled wrongly, leaves a residual count that makes the balance verdict come out wrong.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  typedef enum logic {SCAN_IDLE = 1'b0, SCAN_RUN = 1'b1} scan_state_e;

  function automatic logic [1:0] use_hits(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/fmc_entry_bank.sv
module fmc_entry_bank #(
  parameter int ID_W  = 5,
  parameter int VAL_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clr,
  input  logic                              ins0_vld,
  input  logic [ID_W-1:0]                   ins0_id,
  input  logic [VAL_W-1:0]                  ins0_val,
  input  logic [CNT_W-1:0]                  ins0_fan,
  input  logic                              ins1_vld,
  input  logic [ID_W-1:0]                   ins1_id,
  input  logic [VAL_W-1:0]                  ins1_val,
  input  logic [CNT_W-1:0]                  ins1_fan,
  input  logic                              opa_vld,
  input  logic [ID_W-1:0]                   opa_id,
  input  logic                              opb_vld,
  input  logic [ID_W-1:0]                   opb_id,
  output logic [(1<<ID_W)-1:0]              present_o,
  output logic [(1<<ID_W)-1:0][VAL_W-1:0]   val_o,
  output logic [(1<<ID_W)-1:0][CNT_W-1:0]   cnt_o
);
  import fmc_pkg::*;
  localparam int ENTRIES = 1 << ID_W;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic             sel0, sel1, hit_a, hit_b, en;
    logic             pres_d, pres_q;
    logic [VAL_W-1:0] val_d, val_q;
    logic [CNT_W-1:0] base, cnt_d, cnt_q;
    logic [1:0]       hits;

    always_comb begin
      sel0  = ins0_vld && (ins0_id == ID_W'(i));
      sel1  = ins1_vld && (ins1_id == ID_W'(i));
      hit_a = opa_vld && (opa_id == ID_W'(i));
      hit_b = opb_vld && (opb_id == ID_W'(i));
      hits  = use_hits(hit_a, hit_b);
      base  = sel1 ? ins1_fan : (sel0 ? ins0_fan : cnt_q);
      en    = clr | sel0 | sel1 | hit_a | hit_b;
      if (clr) begin
        pres_d = 1'b0;
        val_d  = '0;
        cnt_d  = '0;
      end else begin
        pres_d = pres_q | sel0 | sel1;
        val_d  = sel1 ? ins1_val : (sel0 ? ins0_val : val_q);
        cnt_d  = base - CNT_W'(hits);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q <= 1'b0;
        val_q  <= '0;
        cnt_q  <= '0;
      end else if (en) begin
        pres_q <= pres_d;
        val_q  <= val_d;
        cnt_q  <= cnt_d;
      end
    end

    assign present_o[i] = pres_q;
    assign val_o[i]     = val_q;
    assign cnt_o[i]     = cnt_q;
  end

  // R1: a clear empties every entry
  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (present_o == '0));

  // R2: a lone slot-0 creation loads value and budget
  assert_insert_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins0_vld && !clr && !(ins1_vld && ins1_id == ins0_id)
     && !(opa_vld && opa_id == ins0_id) && !(opb_vld && opb_id == ins0_id))
    |=> (cnt_o[$past(ins0_id)] == $past(ins0_fan)) && (val_o[$past(ins0_id)] == $past(ins0_val))
        && present_o[$past(ins0_id)]);

  // R4: both operands on one node spend two uses at once
  assert_double_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && opa_vld && opb_vld && opa_id == opb_id
     && !(ins0_vld && ins0_id == opa_id) && !(ins1_vld && ins1_id == opa_id))
    |=> (cnt_o[$past(opa_id)] == $past(cnt_o[opa_id]) - CNT_W'(2)));
endmodule

// File: rtl/fmc_probe.sv
module fmc_probe #(
  parameter int ID_W  = 5,
  parameter int VAL_W = 16
) (
  input  logic                            vld,
  input  logic [ID_W-1:0]                 id,
  input  logic [VAL_W-1:0]                val,
  input  logic [(1<<ID_W)-1:0]            present,
  input  logic [(1<<ID_W)-1:0][VAL_W-1:0] vals,
  output logic                            miss
);
  always_comb begin
    miss = vld && (!present[id] || (vals[id] != val));
  end
endmodule

// File: rtl/fmc_scan.sv
module fmc_scan #(
  parameter int ID_W  = 5,
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            start,
  input  logic [(1<<ID_W)-1:0][CNT_W-1:0] cnts,
  output logic                            done_o,
  output logic                            bal_o
);
  import fmc_pkg::*;
  localparam logic [ID_W-1:0] LAST = ID_W'((1 << ID_W) - 1);

  scan_state_e     st_q, st_d;
  logic [ID_W-1:0] idx_q, idx_d;
  logic            acc_q, acc_d, done_q, done_d, bal_q, bal_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    done_d = done_q;
    bal_d  = bal_q;
    if (clr) begin
      st_d   = SCAN_IDLE;
      done_d = 1'b0;
      bal_d  = 1'b0;
    end else if (start) begin
      st_d   = SCAN_RUN;
      idx_d  = '0;
      acc_d  = 1'b1;
      done_d = 1'b0;
    end else if (st_q == SCAN_RUN) begin
      acc_d = acc_q && (cnts[idx_q] == '0);
      if (idx_q == LAST) begin
        st_d   = SCAN_IDLE;
        done_d = 1'b1;
        bal_d  = acc_d;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      idx_q  <= '0;
      acc_q  <= 1'b0;
      done_q <= 1'b0;
      bal_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
      done_q <= done_d;
      bal_q  <= bal_d;
    end
  end

  assign done_o = done_q;
  assign bal_o  = bal_q;

  // R8: completion only follows the last step of a running scan
  assert_done_after_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st_q) == SCAN_RUN) && ($past(idx_q) == LAST));
endmodule

// File: rtl/fanout_wire_checker.sv
module fanout_wire_checker #(
  parameter int ID_W  = 5,
  parameter int VAL_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ins0_vld_i,
  input  logic [ID_W-1:0]  ins0_id_i,
  input  logic [VAL_W-1:0] ins0_val_i,
  input  logic [CNT_W-1:0] ins0_fan_i,
  input  logic             ins1_vld_i,
  input  logic [ID_W-1:0]  ins1_id_i,
  input  logic [VAL_W-1:0] ins1_val_i,
  input  logic [CNT_W-1:0] ins1_fan_i,
  input  logic             opa_vld_i,
  input  logic [ID_W-1:0]  opa_id_i,
  input  logic [VAL_W-1:0] opa_val_i,
  input  logic             opb_vld_i,
  input  logic [ID_W-1:0]  opb_id_i,
  input  logic [VAL_W-1:0] opb_val_i,
  input  logic             end_i,
  output logic             err_o,
  output logic             done_o,
  output logic             bal_o
);
  localparam int ENTRIES = 1 << ID_W;
  localparam int N_OPS   = 2;

  logic [ENTRIES-1:0]            present;
  logic [ENTRIES-1:0][VAL_W-1:0] vals;
  logic [ENTRIES-1:0][CNT_W-1:0] cnts;
  logic [N_OPS-1:0]              op_vld, miss;
  logic [N_OPS-1:0][ID_W-1:0]    op_id;
  logic [N_OPS-1:0][VAL_W-1:0]   op_val;
  logic                          err_d, err_q;

  assign op_vld = {opb_vld_i, opa_vld_i};
  assign op_id  = {opb_id_i, opa_id_i};
  assign op_val = {opb_val_i, opa_val_i};

  fmc_entry_bank #(.ID_W(ID_W), .VAL_W(VAL_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr_i),
    .ins0_vld(ins0_vld_i), .ins0_id(ins0_id_i), .ins0_val(ins0_val_i), .ins0_fan(ins0_fan_i),
    .ins1_vld(ins1_vld_i), .ins1_id(ins1_id_i), .ins1_val(ins1_val_i), .ins1_fan(ins1_fan_i),
    .opa_vld(opa_vld_i), .opa_id(opa_id_i), .opb_vld(opb_vld_i), .opb_id(opb_id_i),
    .present_o(present), .val_o(vals), .cnt_o(cnts)
  );

  for (genvar k = 0; k < N_OPS; k++) begin : g_probe
    fmc_probe #(.ID_W(ID_W), .VAL_W(VAL_W)) u_probe (
      .vld(op_vld[k]), .id(op_id[k]), .val(op_val[k]),
      .present(present), .vals(vals), .miss(miss[k])
    );
  end

  fmc_scan #(.ID_W(ID_W), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .start(end_i),
    .cnts(cnts), .done_o(done_o), .bal_o(bal_o)
  );

  always_comb begin
    err_d = clr_i ? 1'b0 : (err_q | (|miss));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  // R7: the error holds until a clear
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_i) |=> err_q);

  // R5: a read of a node absent from the table raises the error
  assert_absent_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && opa_vld_i && !present[opa_id_i]) |=> err_q);

  // R6: a read whose value disagrees with the table raises the error
  assert_value_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && opb_vld_i && present[opb_id_i] && (vals[opb_id_i] != opb_val_i)) |=> err_q);

  // R1: a clear drops the error
  assert_clear_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !err_q && !done_o);
endmodule

// File: tb/tb_fanout_wire_checker.sv
module tb_fanout_wire_checker;
  localparam int ID_W  = 5;
  localparam int VAL_W = 16;
  localparam int CNT_W = 16;
  localparam int N     = 1 << ID_W;

  logic clk = 1'b0;
  logic rst_n;
  logic clr_i, end_i;
  logic ins0_vld_i, ins1_vld_i, opa_vld_i, opb_vld_i;
  logic [ID_W-1:0]  ins0_id_i, ins1_id_i, opa_id_i, opb_id_i;
  logic [VAL_W-1:0] ins0_val_i, ins1_val_i, opa_val_i, opb_val_i;
  logic [CNT_W-1:0] ins0_fan_i, ins1_fan_i;
  logic err_o, done_o, bal_o;

  always #5 clk = ~clk;

  fanout_wire_checker #(.ID_W(ID_W), .VAL_W(VAL_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .ins0_vld_i(ins0_vld_i), .ins0_id_i(ins0_id_i), .ins0_val_i(ins0_val_i), .ins0_fan_i(ins0_fan_i),
    .ins1_vld_i(ins1_vld_i), .ins1_id_i(ins1_id_i), .ins1_val_i(ins1_val_i), .ins1_fan_i(ins1_fan_i),
    .opa_vld_i(opa_vld_i), .opa_id_i(opa_id_i), .opa_val_i(opa_val_i),
    .opb_vld_i(opb_vld_i), .opb_id_i(opb_id_i), .opb_val_i(opb_val_i),
    .end_i(end_i), .err_o(err_o), .done_o(done_o), .bal_o(bal_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference
  bit      m_pres[N];
  int      m_val[N];
  shortint m_cnt[N];
  bit      m_err, m_done, m_bal, m_scan;
  int      m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr_i) begin
      for (int i = 0; i < N; i++) begin
        m_pres[i] = 0; m_val[i] = 0; m_cnt[i] = 0;
      end
      m_err = 0; m_done = 0; m_bal = 0; m_scan = 0; m_left = 0;
    end else begin
      if (opa_vld_i && (!m_pres[opa_id_i] || m_val[opa_id_i] != int'(opa_val_i))) m_err = 1;
      if (opb_vld_i && (!m_pres[opb_id_i] || m_val[opb_id_i] != int'(opb_val_i))) m_err = 1;
      if (end_i) begin
        m_scan = 1; m_left = N; m_done = 0;
      end else if (m_scan) begin
        m_left--;
        if (m_left == 0) begin
          m_scan = 0; m_done = 1; m_bal = 1;
          for (int i = 0; i < N; i++) if (m_cnt[i] != 0) m_bal = 0;
        end
      end
      if (ins0_vld_i) begin
        m_pres[ins0_id_i] = 1; m_val[ins0_id_i] = int'(ins0_val_i); m_cnt[ins0_id_i] = shortint'(ins0_fan_i);
      end
      if (ins1_vld_i) begin
        m_pres[ins1_id_i] = 1; m_val[ins1_id_i] = int'(ins1_val_i); m_cnt[ins1_id_i] = shortint'(ins1_fan_i);
      end
      if (opa_vld_i) m_cnt[opa_id_i] = m_cnt[opa_id_i] - 1;
      if (opb_vld_i) m_cnt[opb_id_i] = m_cnt[opb_id_i] - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (err_o !== m_err) begin
        errors++;
        $display("FAIL %s err_o actual=%0b expected=%0b t=%0t", cur_req, err_o, m_err, $time);
      end
      checks++;
      if (done_o !== m_done) begin
        errors++;
        $display("FAIL %s done_o actual=%0b expected=%0b t=%0t", cur_req, done_o, m_done, $time);
      end
      if (m_done) begin
        checks++;
        if (bal_o !== m_bal) begin
          errors++;
          $display("FAIL %s bal_o actual=%0b expected=%0b t=%0t", cur_req, bal_o, m_bal, $time);
        end
      end
    end
  end

  task automatic idle_inputs();
    clr_i = 0; end_i = 0;
    ins0_vld_i = 0; ins0_id_i = '0; ins0_val_i = '0; ins0_fan_i = '0;
    ins1_vld_i = 0; ins1_id_i = '0; ins1_val_i = '0; ins1_fan_i = '0;
    opa_vld_i = 0; opa_id_i = '0; opa_val_i = '0;
    opb_vld_i = 0; opb_id_i = '0; opb_val_i = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic put(input int slot, input int id, input int val, input int fan);
    if (slot == 0) begin
      ins0_vld_i = 1; ins0_id_i = ID_W'(id); ins0_val_i = VAL_W'(val); ins0_fan_i = CNT_W'(fan);
    end else begin
      ins1_vld_i = 1; ins1_id_i = ID_W'(id); ins1_val_i = VAL_W'(val); ins1_fan_i = CNT_W'(fan);
    end
  endtask

  task automatic get(input int slot, input int id, input int val);
    if (slot == 0) begin
      opa_vld_i = 1; opa_id_i = ID_W'(id); opa_val_i = VAL_W'(val);
    end else begin
      opb_vld_i = 1; opb_id_i = ID_W'(id); opb_val_i = VAL_W'(val);
    end
  endtask

  task automatic clear();
    clr_i = 1;
    tick();
  endtask

  // R8: explicit completion check with a verdict worked out by hand
  task automatic scan_expect(input bit exp_bal, input string req);
    end_i = 1;
    tick();
    for (int i = 0; i < N - 1; i++) tick();
    checks++;
    if (done_o !== 1'b0) begin
      errors++;
      $display("FAIL R8 done_o early actual=%0b expected=0", done_o);
    end
    tick();
    checks++;
    if (done_o !== 1'b1 || bal_o !== exp_bal) begin
      errors++;
      $display("FAIL %s done/bal actual=%0b/%0b expected=1/%0b", req, done_o, bal_o, exp_bal);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(); tick();

    cur_req = "R1";
    clear();

    // R2 R3 R9: read pair, a padding node, then two evaluation steps
    cur_req = "R2";
    put(0, 0, 5, 1); put(1, 1, 7, 2); tick();
    cur_req = "R9";
    put(0, 2, 9, 0); tick();
    cur_req = "R3";
    put(0, 3, 12, 1); get(0, 0, 5); get(1, 1, 7); tick();
    put(0, 4, 0, 0); get(0, 1, 7); get(1, 3, 12); tick();
    scan_expect(1'b1, "R8");

    // R4: both operands on one node
    cur_req = "R4";
    clear();
    put(0, 0, 3, 2); tick();
    get(0, 0, 3); get(1, 0, 3); put(0, 1, 9, 0); tick();
    scan_expect(1'b1, "R4");

    // R9: over-consumption leaves a negative count
    cur_req = "R9";
    clear();
    put(0, 6, 1, 1); tick();
    get(0, 6, 1); get(1, 6, 1); tick();
    scan_expect(1'b0, "R9");

    // R9: under-consumption
    clear();
    put(1, 9, 2, 2); tick();
    get(1, 9, 2); tick();
    scan_expect(1'b0, "R9");

    // R5 R7 R1: absent read, stickiness, clear
    cur_req = "R5";
    clear();
    get(0, 7, 0); tick();
    cur_req = "R7";
    repeat (4) tick();
    checks++;
    if (err_o !== 1'b1) begin
      errors++;
      $display("FAIL R7 err_o actual=%0b expected=1", err_o);
    end
    cur_req = "R1";
    clr_i = 1; put(0, 3, 3, 3); get(0, 7, 0); tick();
    checks++;
    if (err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 err_o actual=%0b expected=0", err_o);
    end
    scan_expect(1'b1, "R1");

    // R6: value mismatch still spends the use
    cur_req = "R6";
    clear();
    put(0, 0, 4, 1); tick();
    get(1, 0, 5); tick();
    scan_expect(1'b1, "R6");

    // R2: same identifier on both slots, slot 1 wins
    cur_req = "R2";
    clear();
    put(0, 2, 1, 3); put(1, 2, 2, 1); tick();
    get(0, 2, 2); tick();
    scan_expect(1'b1, "R2");

    // R10: creation and read of one identifier in the same cycle
    cur_req = "R10";
    clear();
    put(0, 5, 8, 1); get(0, 5, 8); tick();
    tick();
    scan_expect(1'b1, "R10");

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule